// File: doc/BRIEF.md
# Synchronous Late-Write SRAM with Zero Turnaround

This block is an on-chip word memory with the cycle behaviour of a synchronous SRAM whose write data trails its command. Address, read/write control, chip selects and byte write strobes are all taken on the rising clock edge. The data for a write arrives on a separate input bus one or two edges after the command. Because of this lag, reads and writes can follow each other on every cycle with no idle slot between them. A read that falls inside the lag window still sees the newest bytes.

A static mode input is captured during reset and selects the latency. The registered mode puts the read data in an output register, and write data follows two edges after the command. The unregistered mode drives read data straight from the array, and write data follows one edge after the command. Each word is built from 9-bit bytes, and each byte has its own write strobe. Three chip selects must all be active for a command to take effect. An output-enable input gates the read bus at once, with no clock involved. A sleep input blocks new commands. The read bus is shown as a data vector plus a drive flag. The data vector is all zeros while the drive flag is low.

Top module: `nbt_sram`

## Requirements
- R1: A command is taken only on an edge where sel_a_n=0, sel_b=1 and sel_c_n=0. Any other combination acts as a deselect: no write happens, and no read data is driven for that slot.
- R2: In registered mode (flow_mode=0 at reset), a read taken at edge k drives dout_drv=1 and dout=word between edge k+1 and edge k+2.
- R3: In unregistered mode (flow_mode=1 at reset), a read taken at edge k drives dout_drv=1 and dout=word between edge k and edge k+1.
- R4: In registered mode, the data for a write taken at edge k is sampled from din at edge k+2.
- R5: In unregistered mode, the data for a write taken at edge k is sampled from din at edge k+1.
- R6: byte_wr_n[b]=0 writes bits [9b+8:9b] of the word. Bytes whose strobe is 1 keep their old value.
- R7: Reads and writes may alternate on every edge. A read always returns the most recent written bytes, including write data still in flight in the same cycle.
- R8: A deselected or empty slot leaves dout_drv=0 during its data interval. Writes already taken still complete across such slots.
- R9: out_en_n=1 forces dout_drv=0 at once, without waiting for a clock edge. Clearing it restores the drive.
- R10: A command taken while sleep=1 is ignored: a write leaves the memory unchanged, and a read drives no data.
- R11: flow_mode is sampled only while rst_n=0. Changing it later has no effect on latency.
- R12: After reset, no write is pending and dout_drv=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_mode | input | 1 | 1 = unregistered read path, 0 = registered; taken during reset |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| addr | input | ADDR_W | Word address |
| byte_wr_n | input | BYTES | Per-byte write strobes, active low |
| din | input | 9*BYTES | Late write data |
| out_en_n | input | 1 | Output enable, active low, acts without the clock |
| sleep | input | 1 | Blocks new commands while high |
| dout | output | 9*BYTES | Read data, zero when not driven |
| dout_drv | output | 1 | High when dout carries read data |

## Verification
The bench builds the block with ADDR_W=4 and BYTES=2: 16 words of two 9-bit bytes. This size lets it sweep every address, every one of the four strobe patterns on each address, and each chip-select combination, in both latency modes. The bench runs every sequence twice, once per mode, and toggles flow_mode right after reset each time. Write-then-read pairs on the same address exercise the in-flight forwarding path in registered mode.

// File: rtl/nbt_pkg.sv
// Shared definitions for the late-write SRAM.
// Assumes a byte is always 9 bits wide.
package nbt_pkg;
    localparam int BYTE_BITS = 9;

    typedef enum logic {
        LAT_REG  = 1'b0,
        LAT_FLOW = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/nbt_cmd_pipe.sv
// Command capture and late-write scheduling.
// Captures the select, direction, address and strobes on each edge and
// keeps two stages of command history. Issues the array write when the
// matching data is present on din: from stage 1 in unregistered mode, from
// stage 2 in registered mode.
// Assumes the latency mode is latched only during reset.
module nbt_cmd_pipe
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_mode,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  byte_wr_n,
    input  logic              sleep,
    output lat_mode_e         mode,
    output logic              s1_rd,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              s2_wr,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [BYTES-1:0]  s2_be,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [BYTES-1:0]  commit_be
);
    lat_mode_e         mode_q;
    logic              sel_now;
    logic              s1_vld, s1_wr;
    logic [BYTES-1:0]  s1_be;
    logic              s2_vld, s2_wr_q;

    // Command is live only with all three selects active and no sleep
    always_comb sel_now = !sel_a_n && sel_b && !sel_c_n && !sleep;

    // Mode latch: loaded during reset, held afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= flow_mode ? LAT_FLOW : LAT_REG;
    end

    // Two-stage command history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_be   <= '0;
            s2_vld  <= 1'b0;
            s2_wr_q <= 1'b0;
            s2_addr <= '0;
            s2_be   <= '0;
        end else begin
            s1_vld  <= sel_now;
            s1_wr   <= !wr_n;
            s1_addr <= addr;
            s1_be   <= ~byte_wr_n;
            s2_vld  <= s1_vld;
            s2_wr_q <= s1_wr;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    // Stage views for the read path
    always_comb begin
        mode  = mode_q;
        s1_rd = s1_vld && !s1_wr;
        s2_wr = s2_vld && s2_wr_q;
    end

    // Array write source chosen by latency mode
    always_comb begin
        if (mode_q == LAT_FLOW) begin
            commit_en   = s1_vld && s1_wr;
            commit_addr = s1_addr;
            commit_be   = s1_be;
        end else begin
            commit_en   = s2_vld && s2_wr_q;
            commit_addr = s2_addr;
            commit_be   = s2_be;
        end
    end

    // R1
    desel_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n || !sel_b || sel_c_n) |=> !s1_vld);
    // R10
    sleep_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !s1_vld);
    // R4
    reg_late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAT_REG && s1_vld && s1_wr) |=> (commit_en && commit_addr == $past(s1_addr)));
    // R5
    flow_late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAT_FLOW && sel_now && !wr_n) |=> (commit_en && commit_addr == $past(addr)));
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/nbt_store.sv
// Word array with per-byte write strobes and a combinational read port.
// Built from flops so that the unregistered read mode has data in the
// cycle of the command. Assumes a single write per edge.
module nbt_store
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTES-1:0]           wr_be,
    input  logic [BYTES*BYTE_BITS-1:0] wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [BYTES*BYTE_BITS-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = BYTES * BYTE_BITS;

    logic [DW-1:0] mem [DEPTH];

    // Byte-masked array write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BYTE_BITS +: BYTE_BITS] <= wr_data[b*BYTE_BITS +: BYTE_BITS];
            end
        end
    end

    // Asynchronous read port
    always_comb rd_data = mem[rd_addr];

    for (genvar g = 0; g < BYTES; g++) begin : g_byte_chk
        // R6
        byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_be[g]) |=>
            mem[$past(wr_addr)][g*BYTE_BITS +: BYTE_BITS] == $past(mem[wr_addr][g*BYTE_BITS +: BYTE_BITS]));
        // R6
        byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_be[g]) |=>
            mem[$past(wr_addr)][g*BYTE_BITS +: BYTE_BITS] == $past(wr_data[g*BYTE_BITS +: BYTE_BITS]));
    end
endmodule

// File: rtl/nbt_out_stage.sv
// Read data path: merges in-flight write bytes, holds the output register,
// and gates the bus with the output enable.
// In registered mode the only write not yet in the array when a read looks
// at it is the one whose data is on din in the same cycle, so one compare
// against stage 2 is enough. Unregistered mode reads the array directly.
module nbt_out_stage
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  lat_mode_e                  mode,
    input  logic                       s1_rd,
    input  logic [ADDR_W-1:0]          s1_addr,
    input  logic                       s2_wr,
    input  logic [ADDR_W-1:0]          s2_addr,
    input  logic [BYTES-1:0]           s2_be,
    input  logic [BYTES*BYTE_BITS-1:0] arr_word,
    input  logic [BYTES*BYTE_BITS-1:0] din,
    input  logic                       out_en_n,
    output logic [BYTES*BYTE_BITS-1:0] dout,
    output logic                       dout_drv
);
    localparam int DW = BYTES * BYTE_BITS;

    logic          fwd_hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] out_q;
    logic          out_vld;
    logic          slot_rd;
    logic [DW-1:0] slot_word;

    // Address match against the write whose data is on din now
    always_comb fwd_hit = s2_wr && (s2_addr == s1_addr);

    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        // Per-byte choice between in-flight data and array contents
        always_comb merged[b*BYTE_BITS +: BYTE_BITS] = (fwd_hit && s2_be[b])
            ? din[b*BYTE_BITS +: BYTE_BITS] : arr_word[b*BYTE_BITS +: BYTE_BITS];
    end

    // Output register for the registered mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else begin
            out_vld <= s1_rd;
            if (s1_rd) out_q <= merged;
        end
    end

    // Slot selection by mode
    always_comb begin
        if (mode == LAT_REG) begin
            slot_rd   = out_vld;
            slot_word = out_q;
        end else begin
            slot_rd   = s1_rd;
            slot_word = arr_word;
        end
    end

    // Bus gating, output enable acts without the clock
    always_comb begin
        dout_drv = slot_rd && !out_en_n;
        dout     = dout_drv ? slot_word : '0;
    end

    // R2
    reg_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LAT_REG && s1_rd) |=> (out_en_n || dout_drv));
    // R8
    reg_idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LAT_REG && !s1_rd) |=> !dout_drv);
    // R7
    fwd_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_rd && fwd_hit && (&s2_be)) |=> out_q == $past(din));
endmodule

// File: rtl/nbt_sram.sv
// Top of the late-write SRAM: command pipeline, array and read path.
// Assumes the caller drives din for each write in the cycle fixed by the
// latency mode. All inputs except out_en_n are used at the clock edge.
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flow_mode,
    input  logic                       sel_a_n,
    input  logic                       sel_b,
    input  logic                       sel_c_n,
    input  logic                       wr_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTES-1:0]           byte_wr_n,
    input  logic [BYTES*BYTE_BITS-1:0] din,
    input  logic                       out_en_n,
    input  logic                       sleep,
    output logic [BYTES*BYTE_BITS-1:0] dout,
    output logic                       dout_drv
);
    localparam int DW = BYTES * BYTE_BITS;

    lat_mode_e         mode;
    logic              s1_rd, s2_wr, commit_en;
    logic [ADDR_W-1:0] s1_addr, s2_addr, commit_addr;
    logic [BYTES-1:0]  s2_be, commit_be;
    logic [DW-1:0]     arr_word;

    nbt_cmd_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) cmd_i (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_n(wr_n), .addr(addr), .byte_wr_n(byte_wr_n), .sleep(sleep),
        .mode(mode), .s1_rd(s1_rd), .s1_addr(s1_addr),
        .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_be(s2_be),
        .commit_en(commit_en), .commit_addr(commit_addr), .commit_be(commit_be)
    );

    nbt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_en), .wr_addr(commit_addr), .wr_be(commit_be), .wr_data(din),
        .rd_addr(s1_addr), .rd_data(arr_word)
    );

    nbt_out_stage #(.ADDR_W(ADDR_W), .BYTES(BYTES)) out_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .s1_rd(s1_rd), .s1_addr(s1_addr),
        .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_be(s2_be),
        .arr_word(arr_word), .din(din), .out_en_n(out_en_n),
        .dout(dout), .dout_drv(dout_drv)
    );
endmodule

// File: tb/nbt_sram_tb_top.sv
// Sweep bench for nbt_sram with 16 words of two 9-bit bytes, run in both modes.
module nbt_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int DW = NB * 9;
    localparam int NW = 1 << AW;
    localparam logic [DW-1:0] JUNK = 18'h2AAAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flow_mode = 1'b0;
    logic sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] byte_wr_n = '1;
    logic [DW-1:0] din = '0;
    logic out_en_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dout;
    logic dout_drv;

    int checks = 0, errors = 0, stamp = 0;
    bit cur_flow = 1'b0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [NW];
    int            h_kind [2];
    int            h_addr [2];
    int            h_ben  [2];
    logic [DW-1:0] h_data [2];

    nbt_sram #(.ADDR_W(AW), .BYTES(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
        .addr(addr), .byte_wr_n(byte_wr_n), .din(din),
        .out_en_n(out_en_n), .sleep(sleep), .dout(dout), .dout_drv(dout_drv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(int a, int s);
        return DW'((a * 12345 + s * 7919 + 3) & 32'h3FFFF);
    endfunction

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One bus cycle: check the current data slot, drive late data, issue a command.
    // kind: 0 idle, 1 read, 2 write. desel: 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high.
    task automatic step(int kind, int a, int ben, int desel, bit slp, bit oe_pulse, string tag);
        int ix;
        logic [DW-1:0] d;
        @(negedge clk);
        ix = cur_flow ? 0 : 1;
        if (h_kind[ix] == 1) begin
            chk(dout_drv === 1'b1, {tag, " drive"}, DW'(dout_drv), 1);
            chk(dout === ref_mem[h_addr[ix]], {tag, " data"}, dout, ref_mem[h_addr[ix]]);
            if (oe_pulse) begin
                out_en_n = 1'b1;
                #1;
                chk(dout_drv === 1'b0, "R9 off", DW'(dout_drv), 0);
                out_en_n = 1'b0;
                #1;
                chk(dout_drv === 1'b1, "R9 on", DW'(dout_drv), 1);
            end
        end else begin
            chk(dout_drv === 1'b0, {tag, " R8 idle"}, DW'(dout_drv), 0);
        end
        if (h_kind[ix] == 2) begin
            din = h_data[ix];
            for (int b = 0; b < NB; b++)
                if (!h_ben[ix][b]) ref_mem[h_addr[ix]][b*9 +: 9] = h_data[ix][b*9 +: 9];
        end else begin
            din = JUNK;
        end
        sel_a_n   = (kind == 0) || (desel == 1);
        sel_b     = (desel != 2);
        sel_c_n   = (desel == 3);
        wr_n      = (kind != 2);
        addr      = AW'(a);
        byte_wr_n = NB'(ben);
        sleep     = slp;
        d = pat(a, stamp);
        stamp++;
        @(posedge clk);
        h_kind[1] = h_kind[0]; h_addr[1] = h_addr[0]; h_ben[1] = h_ben[0]; h_data[1] = h_data[0];
        h_kind[0] = (kind == 0 || desel != 0 || slp) ? 0 : kind;
        h_addr[0] = a; h_ben[0] = ben; h_data[0] = d;
    endtask

    task automatic do_reset(bit m);
        @(negedge clk);
        rst_n = 1'b0; flow_mode = m; sel_a_n = 1'b1; sleep = 1'b0; out_en_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        flow_mode = !m;  // R11: later changes must not alter the latency
        cur_flow = m;
        for (int i = 0; i < 2; i++) h_kind[i] = 0;
        chk(dout_drv === 1'b0, "R12 reset", DW'(dout_drv), 0);
    endtask

    task automatic run_mode(bit m);
        string tr, tw, tg;
        tr = m ? "R3" : "R2";
        tw = m ? "R5" : "R4";
        tg = {tr, " ", tw, " R11"};
        do_reset(m);
        step(0, 0, 3, 0, 0, 0, "R12 empty");
        step(0, 0, 3, 0, 0, 0, "R12 empty");
        for (int a = 0; a < NW; a++) step(2, a, 0, 0, 0, 0, tg);
        for (int a = 0; a < NW; a++) step(1, a, 0, 0, 0, (a == 5), tg);
        // R7: write then immediate read of the same word, then neighbours
        for (int a = 0; a < NW; a++) begin
            step(2, a, 0, 0, 0, 0, {"R7 ", tg});
            step(1, a, 0, 0, 0, 0, {"R7 ", tg});
            step(1, (a + 1) % NW, 0, 0, 0, 0, {"R7 ", tg});
            step(2, a, 2, 0, 0, 0, {"R7 ", tg});
            step(1, a, 0, 0, 0, 0, {"R7 ", tg});
        end
        // R6: every strobe pattern on every word
        for (int a = 0; a < NW; a++)
            for (int ben = 0; ben < 4; ben++) begin
                step(2, a, ben, 0, 0, 0, {"R6 ", tg});
                step(1, a, 0, 0, 0, 0, {"R6 ", tg});
            end
        // R1, R8: each deselect form blocks writes and reads
        for (int ds = 1; ds <= 3; ds++) begin
            step(2, 3, 0, ds, 0, 0, "R1");
            step(1, 3, 0, ds, 0, 0, "R1");
            step(1, 3, 0, 0, 0, 0, "R1 R8");
            step(0, 0, 3, 0, 0, 0, "R1 R8");
        end
        // R8: a write completes across following deselected slots
        step(2, 7, 0, 0, 0, 0, "R8");
        step(1, 7, 0, 1, 0, 0, "R8");
        step(1, 7, 0, 3, 0, 0, "R8");
        step(1, 7, 0, 0, 0, 0, "R8");
        step(0, 0, 3, 0, 0, 0, "R8");
        // R10: commands during sleep are ignored
        step(2, 9, 0, 0, 1, 0, "R10");
        step(1, 9, 0, 0, 1, 0, "R10");
        step(1, 9, 0, 0, 0, 0, "R10");
        step(0, 0, 3, 0, 0, 0, "R10");
        step(0, 0, 3, 0, 0, 0, "R10");
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            h_kind[i] = 0; h_addr[i] = 0; h_ben[i] = 3; h_data[i] = '0;
        end
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule